// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port with Write-Collision Detection

This block is an 8-bit serial peripheral port. A control bit makes it the bus master or a slave. A small register interface gives software three locations: control, status and data. In both roles the port is full duplex. Each outgoing bit leaves the shift register on the same serial clock that brings an incoming bit in, so after eight bits the shift register holds the received byte in place of the byte sent. There is one completion flag for both directions, and there are no separate transmit and receive flags.

Writes to the data location are single-buffered. A write goes straight into the shift register, and it is refused while a byte is in flight. Reads are double-buffered. They return a receive buffer that is copied from the shift register only when a byte completes.

As master, a write to the data location starts a burst of eight clocks on SCK. The speed is set by a 2-bit rate field. As slave, the port follows SCK and the active-low select from an external master, both passed through synchronizers. A byte that software writes waits in the shift register until the master clocks it out.

Top module: `spi_port`

## Requirements
- R1: Address 0 is control: bit0 enable, bit1 master, bit2 idle level of SCK, bit3 phase, bits5:4 rate. Address 1 is status: bit7 completion flag, bit6 collision flag. Address 2 is data. Read data appears on `bus_rdata` in the cycle after the read strobe. After reset, all three read as zero and both `sck_oe` and `miso_oe` are low.
- R2: Every transfer moves exactly 8 bits, most significant bit first, in both directions at once. The byte received replaces the byte sent.
- R3: A read of the data location returns the receive buffer. The buffer changes only when a byte completes. A write to the data location does not alter what is read back from it.
- R4: The completion flag sets once at the end of each complete 8-bit transfer.
- R5: A data write while a transfer is in progress is discarded and sets the collision flag. The transfer in progress finishes with its original data.
- R6: A flag clears only after a status read that sees it set, followed by a read or write of the data location. A status read alone leaves the flags set.
- R7: As master, SCK rests at the idle level. A data write produces exactly 16 SCK edges, after which SCK returns to the idle level. Each half period lasts 1, 2, 8 or 16 system cycles for rate codes 0, 1, 2 and 3.
- R8: With phase 0, the first bit is driven before the first edge, input is sampled on the leading edge and output changes on the trailing edge. With phase 1, output changes on the leading edge and input is sampled on the trailing edge. The leading edge is the edge that leaves the idle level.
- R9: As slave, the port shifts only while `ss_n` is low. It samples `mosi_i` and drives `miso_o`, with `miso_oe` high only while selected. A preloaded byte goes out on the master's clocks.
- R10: If `ss_n` rises in the middle of a byte, the bit count resets and `miso_oe` drops. The completion flag does not set, and the next full byte transfers correctly.
- R11: Clearing enable aborts a transfer in progress. The completion flag does not set, and the next transfer runs correctly from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock drive enable (enabled master) |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n | input | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out as master |
| mosi_i | input | 1 | Serial data in as slave |
| miso_i | input | 1 | Serial data in as master |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | Slave data drive enable |

## Verification
The bench builds the port with its default 8-bit width and a two-stage synchronizer. That size allows every combination of idle level and phase to be swept over all four master rates and several byte patterns against a serial peer modelled in the bench. The half-period length is measured in system cycles on each run. The same four modes are then swept with the port as slave, including a preload and a select abort in the middle of a byte. Collision, the two-step flag clear and an abort through the enable bit are each driven in isolation.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CB_EN   = 0;
  localparam int CB_MSTR = 1;
  localparam int CB_POL  = 2;
  localparam int CB_PHA  = 3;
  localparam int CB_RATE = 4;

  localparam int DIV_CNT_W = 5;

  // half period of the master serial clock, in system cycles
  function automatic logic [DIV_CNT_W-1:0] half_cycles(input logic [1:0] rate);
    case (rate)
      2'd0:    half_cycles = 5'd1;
      2'd1:    half_cycles = 5'd2;
      2'd2:    half_cycles = 5'd8;
      default: half_cycles = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [DIV_CNT_W-1:0] cnt;
  logic [DIV_CNT_W-1:0] last;

  assign last = half_cycles(rate) - 1'b1;
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              pha,
  input  logic              lead,
  input  logic              trail,
  input  logic              sdin,
  output logic              out_bit,
  output logic [CNT_W-1:0]  bitcnt,
  output logic              mid,
  output logic              complete,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic              samp;

  assign rx_word  = {shreg[DATA_W-2:0], pha ? sdin : samp};
  assign complete = trail && !load && !clr && (bitcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      samp    <= 1'b0;
      out_bit <= 1'b0;
      bitcnt  <= '0;
      mid     <= 1'b0;
    end else if (load) begin
      shreg   <= load_data;
      out_bit <= load_data[DATA_W-1];
      bitcnt  <= '0;
      mid     <= 1'b0;
    end else if (clr) begin
      bitcnt  <= '0;
      mid     <= 1'b0;
      out_bit <= shreg[DATA_W-1];
    end else begin
      if (lead) begin
        mid <= 1'b1;
        if (pha) out_bit <= shreg[DATA_W-1];
        else     samp    <= sdin;
      end
      if (trail) begin
        mid    <= 1'b0;
        shreg  <= rx_word;
        bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
        if (!pha) out_bit <= rx_word[DATA_W-1];
      end
    end
  end

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    complete |=> (bitcnt == '0) && !mid);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  input  logic              ss_n,
  output logic              mosi_o,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  logic [DATA_W-1:0] ctrl_q, rxbuf;
  logic en, mstr, pol, pha;
  logic [1:0] rate;
  assign en   = ctrl_q[CB_EN];
  assign mstr = ctrl_q[CB_MSTR];
  assign pol  = ctrl_q[CB_POL];
  assign pha  = ctrl_q[CB_PHA];
  assign rate = ctrl_q[CB_RATE +: 2];

  // synchronised slave-side inputs
  logic sck_s, ss_s, mosi_s, sck_d;
  spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sck  (.clk(clk), .rst(rst), .d(sck_i),  .q(sck_s));
  spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_ss   (.clk(clk), .rst(rst), .d(ss_n),   .q(ss_s));
  spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_mosi (.clk(clk), .rst(rst), .d(mosi_i), .q(mosi_s));

  logic sck_rise, sck_fall;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  // bus decode
  logic data_wr, data_acc, stat_rd, ctrl_wr;
  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign data_wr  = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
  assign data_acc = bus_sel && (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
  assign stat_rd  = bus_sel && bus_rd && (bus_addr == ADDR_STAT);

  // core handshake
  logic m_active, sck_int, tick;
  logic out_bit, mid, complete;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] rx_word;
  logic busy, load, coll, clr, lead, trail, s_on;

  assign busy  = mstr ? m_active : ((bitcnt != '0) || mid);
  assign load  = data_wr && !busy;
  assign coll  = data_wr && busy;
  assign s_on  = en && !mstr && !ss_s;
  assign clr   = !en || (!mstr && ss_s);
  assign lead  = mstr ? (m_active && tick && (sck_int == pol))
                      : (s_on && (pol ? sck_fall : sck_rise));
  assign trail = mstr ? (m_active && tick && (sck_int != pol))
                      : (s_on && (pol ? sck_rise : sck_fall));

  spi_rate_gen u_rate (.clk(clk), .rst(rst), .run(m_active), .rate(rate), .tick(tick));

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .load_data(bus_wdata),
    .pha(pha), .lead(lead), .trail(trail), .sdin(mstr ? miso_i : mosi_s),
    .out_bit(out_bit), .bitcnt(bitcnt), .mid(mid), .complete(complete),
    .rx_word(rx_word));

  // master clock generation
  always_ff @(posedge clk) begin
    if (rst) begin
      m_active <= 1'b0;
      sck_int  <= 1'b0;
      sck_d    <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (!en || !mstr)               m_active <= 1'b0;
      else if (load)                  m_active <= 1'b1;
      else if (complete)              m_active <= 1'b0;
      if (!m_active || !en || !mstr)  sck_int <= pol;
      else if (tick)                  sck_int <= !sck_int;
    end
  end

  // registers, flags and receive buffer
  logic st_done, st_col, arm_done, arm_col;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      rxbuf     <= '0;
      st_done   <= 1'b0;
      st_col    <= 1'b0;
      arm_done  <= 1'b0;
      arm_col   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q <= bus_wdata;
      if (complete) rxbuf  <= rx_word;

      if (complete)                  st_done <= 1'b1;
      else if (data_acc && arm_done) st_done <= 1'b0;
      if (coll)                      st_col  <= 1'b1;
      else if (data_acc && arm_col)  st_col  <= 1'b0;

      if (stat_rd && st_done) arm_done <= 1'b1;
      else if (data_acc)      arm_done <= 1'b0;
      if (stat_rd && st_col)  arm_col  <= 1'b1;
      else if (data_acc)      arm_col  <= 1'b0;

      if (bus_sel && bus_rd) begin
        case (bus_addr)
          ADDR_CTRL: bus_rdata <= ctrl_q;
          ADDR_STAT: bus_rdata <= {st_done, st_col, {(DATA_W-2){1'b0}}};
          ADDR_DATA: bus_rdata <= rxbuf;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  assign sck_o   = sck_int;
  assign sck_oe  = en && mstr;
  assign mosi_o  = out_bit;
  assign miso_o  = out_bit;
  assign miso_oe = s_on;

  // R4
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_done) |-> $past(trail));
  // R5
  coll_flag_chk: assert property (@(posedge clk) disable iff (rst)
    coll |=> st_col);
  // R3
  rxbuf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !complete |=> $stable(rxbuf));
  // R11
  disable_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !m_active && (bitcnt == '0));
  // R10
  ss_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (!mstr && ss_s && !$past(ss_s)) |=> (bitcnt == '0) && !mid);
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic sck_o, sck_oe, mosi_o, miso_o, miso_oe;
  logic sck_i = 0, ss_n = 1, mosi_i = 0, miso_i = 0;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] last_rx = 8'h00;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_port u_spi_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .ss_n(ss_n),
    .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // poll until the completion flag is seen, then read data (clears flags)
  task automatic wait_done(output logic [7:0] st, output logic [7:0] rx);
    st = 0;
    for (int k = 0; k < 3000 && !st[7]; k++) bus_read(2'd1, st);
    bus_read(2'd2, rx);
  endtask

  task automatic master_xfer(input logic pol, input logic pha, input logic [1:0] rate,
                             input logic [7:0] tx, input logic [7:0] stx, input bit collide);
    logic [7:0] got, rx, st, sh;
    int e0, e1, half;
    half = (rate == 0) ? 1 : (rate == 1) ? 2 : (rate == 2) ? 8 : 16;
    bus_write(2'd0, {2'b00, rate, pha, pol, 1'b1, 1'b1});
    wait_cyc(3);
    chk("R7 idle level", sck_o, pol);
    sh = stx; got = 0; e0 = 0; e1 = 0;
    miso_i = pha ? 1'b0 : stx[7];
    fork
      begin
        for (int i = 0; i < 16; i++) begin
          @(sck_o);
          if (i == 0) e0 = cyc;
          if (i == 1) e1 = cyc;
          if (!pha) begin
            if (i % 2 == 0) got = {got[6:0], mosi_o};
            else begin sh = sh << 1; miso_i = sh[7]; end
          end else begin
            if (i % 2 == 0) begin miso_i = sh[7]; sh = sh << 1; end
            else got = {got[6:0], mosi_o};
          end
        end
      end
      begin
        bus_write(2'd2, tx);
        if (collide) begin
          wait_cyc(2);
          bus_write(2'd2, ~tx);
        end
      end
    join
    if (collide) begin
      bus_read(2'd1, st);
      chk("R5 collision flag with done", st, 8'hC0);
      bus_read(2'd1, st);
      chk("R6 status read alone keeps flags", st, 8'hC0);
      bus_read(2'd2, rx);
      bus_read(2'd1, st);
      chk("R6 flags cleared after data access", st, 8'h00);
    end else begin
      wait_done(st, rx);
      chk("R4 completion flag", st[7], 1);
      bus_read(2'd1, st);
      chk("R6 flags cleared", st, 8'h00);
    end
    chk("R2 R8 master received byte", rx, stx);
    chk("R2 R8 peer received byte", got, collide ? tx : tx);
    chk("R7 half period cycles", e1 - e0, half);
    wait_cyc(2 * half + 2);
    chk("R7 back at idle after 16 edges", sck_o, pol);
    last_rx = rx;
  endtask

  task automatic slave_xfer(input logic pol, input logic pha,
                            input logic [7:0] mtx, input logic [7:0] stx, input int nbits);
    logic [7:0] got, rx;
    got = 0;
    bus_write(2'd0, {4'b0000, pha, pol, 1'b0, 1'b1});
    sck_i = pol; ss_n = 1;
    wait_cyc(6);
    bus_write(2'd2, stx);
    bus_read(2'd2, rx);
    chk("R3 data write does not alter read", rx, last_rx);
    ss_n = 0;
    wait_cyc(8);
    chk("R9 miso_oe while selected", miso_oe, 1);
    for (int b = 0; b < nbits; b++) begin
      if (!pha) begin
        mosi_i = mtx[7-b]; got[7-b] = miso_o;
        wait_cyc(8); sck_i = ~pol;
        wait_cyc(8); sck_i = pol;
        wait_cyc(8);
      end else begin
        sck_i = ~pol; wait_cyc(8);
        mosi_i = mtx[7-b]; got[7-b] = miso_o;
        wait_cyc(8); sck_i = pol;
        wait_cyc(8);
      end
    end
    ss_n = 1;
    wait_cyc(8);
    if (nbits == 8) begin
      logic [7:0] st;
      wait_done(st, rx);
      chk("R4 R9 slave completion", st[7], 1);
      chk("R2 R9 slave received byte", rx, mtx);
      chk("R9 preload shifted out", got, stx);
      last_rx = rx;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wait_cyc(4);
    rst = 0;
    wait_cyc(2);
    chk("R1 reset sck_oe", sck_oe, 0);
    chk("R1 reset miso_oe", miso_oe, 0);
    bus_read(2'd0, v); chk("R1 reset control", v, 0);
    bus_read(2'd1, v); chk("R1 reset status", v, 0);
    bus_read(2'd2, v); chk("R1 reset data", v, 0);

    // master sweep over idle level, phase, rate and patterns (R2 R7 R8)
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++)
        for (int p = 0; p < 3; p++)
          master_xfer(m[0], m[1], r[1:0], 8'(8'hA5 + 37 * p + 11 * m + r),
                      8'(~(8'h5C + 29 * p) ^ (m * 16 + r)), 0);

    // R5 collision during master transfer
    master_xfer(1'b0, 1'b0, 2'd3, 8'h69, 8'hB4, 1);

    // R11 abort via enable
    bus_write(2'd0, 8'h37);
    wait_cyc(3);
    bus_write(2'd2, 8'hF0);
    wait_cyc(40);
    bus_write(2'd0, 8'h36);
    wait_cyc(4);
    chk("R11 sck back to idle", sck_o, 1);
    bus_read(2'd1, v);
    chk("R11 no completion after abort", v[7], 0);
    master_xfer(1'b1, 1'b1, 2'd1, 8'h1E, 8'hD2, 0);

    // slave sweep (R9 R8)
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        slave_xfer(m[0], m[1], 8'(8'h3A + 71 * p + 13 * m), 8'(8'hC5 ^ (p * 8'h5A) ^ m), 8);

    // R10 select released mid-byte
    slave_xfer(1'b0, 1'b0, 8'hAA, 8'hC3, 3);
    chk("R10 miso_oe released", miso_oe, 0);
    bus_read(2'd1, v);
    chk("R10 no completion after abort", v[7], 0);
    slave_xfer(1'b0, 1'b0, 8'h4D, 8'h92, 8);
    chk("R10 following byte correct", last_rx, 8'h4D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule